// File: doc/BRIEF.md
# Single-Slot Keyhole Packet Buffer

This block holds one fixed-size secondary data packet of 36 bytes: a 4-byte header followed by a 32-byte payload. Software reaches it through a small register bus on which each direction has a single keyhole address. The fill side of the transmit slot takes nine back-to-back 32-bit writes to its keyhole. After the ninth write the packet is offered, one byte per accepted beat, to the link framing logic downstream.

The receive slot works the other way. It captures a packet that arrives as a byte stream from the link side. Software then empties it with nine reads of the receive keyhole, and the word pointer returns to word 0 by itself after the last read. Each slot holds one packet only. A packet that arrives while the stored packet has not yet been read is thrown away, and a sticky overrun flag records the loss.

Top module: `kh_pkt_buf`

## Requirements
- R1: After reset the status word reads 0, tx_valid is low and a read of the receive keyhole returns 0.
- R2: Addresses: 0 is the transmit keyhole, 1 is the receive keyhole and 2 is status. Status bit 0 (transmit ready) and tx_valid rise only once the ninth write to address 0 has completed. Eight writes leave both low.
- R3: Word k carries packet bytes 4k to 4k+3, least significant byte first. Bytes 0 to 3 are the header. Bytes leave in order 0 to 35, with tx_first marking byte 0 and tx_last marking byte 35.
- R4: While tx_valid is high and tx_accept is low, tx_valid and tx_data hold. tx_valid falls after byte 35 is accepted.
- R5: Writes to address 0 while transmit ready is set have no effect on the stored packet.
- R6: A byte with rx_start set begins a packet. Once 36 bytes have been received, status bit 1 (packet available) is set.
- R7: Nine reads of address 1 return the stored words in order from word 0. Packet available clears after the ninth read, and the next packet is again read from word 0.
- R8: A packet whose start byte arrives while packet available is set is discarded, and status bit 2 (overrun) is set. The stored packet is unchanged.
- R9: A read of status clears the overrun flag. Status bits 31 to 3, any other address, and the receive keyhole while no packet is available all read 0.
- R10: An rx_start byte in the middle of a packet abandons the partial packet and begins a new one at byte 0.
- R11: Read data appears on bus_rdata one clock after the cycle in which bus_rd is high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_accept | input | 1 | Downstream takes the current byte |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | Current byte is byte 0 |
| tx_last | output | 1 | Current byte is byte 35 |
| rx_valid | input | 1 | Receive byte present |
| rx_start | input | 1 | Receive byte is the first of a packet |
| rx_data | input | 8 | Receive byte |

## Verification
Results fall due at fixed points. bus_rdata is due at the first edge after a read strobe, and transmit ready appears one edge after the ninth write. Packet available and overrun are due one edge after the 36th byte or the refused start byte, and available clears at the edge of the ninth read. The bench drives on the falling edge and samples on the following falling edge. Each result is therefore read exactly one register stage after its cause. tx_data is combinational from the byte pointer, so each byte is checked before the edge that accepts it.

// File: rtl/kh_pkg.sv
package kh_pkg;
    localparam int ADDR_TX_KEY = 0;
    localparam int ADDR_RX_KEY = 1;
    localparam int ADDR_STATUS = 2;
    localparam int ST_TX_READY = 0;
    localparam int ST_RX_AVAIL = 1;
    localparam int ST_RX_OVR   = 2;
    localparam int WORD_BYTES  = 4;
endpackage

// File: rtl/kh_tx_buf.sv
module kh_tx_buf #(
    parameter int WORDS = 9,
    parameter int BYTES = 36
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [31:0] wdata,
    input  logic        accept,
    output logic        ready,
    output logic [7:0]  byte_out,
    output logic        first,
    output logic        last
);
    localparam int WP_W = $clog2(WORDS);
    localparam int BP_W = $clog2(BYTES);

    typedef struct packed {
        logic [WORDS-1:0][31:0] mem;
        logic [WP_W-1:0]        wptr;
        logic [BP_W-1:0]        bptr;
        logic                   ready;
    } tx_state_t;

    tx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_stb && !st_q.ready) begin
            st_d.mem[st_q.wptr] = wdata;
            if (st_q.wptr == WP_W'(WORDS - 1)) begin
                st_d.wptr  = '0;
                st_d.ready = 1'b1;
                st_d.bptr  = '0;
            end else begin
                st_d.wptr = st_q.wptr + 1'b1;
            end
        end
        if (st_q.ready && accept) begin
            if (st_q.bptr == BP_W'(BYTES - 1)) begin
                st_d.bptr  = '0;
                st_d.ready = 1'b0;
            end else begin
                st_d.bptr = st_q.bptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready    = st_q.ready;
    assign byte_out = st_q.mem[st_q.bptr[BP_W-1:2]][st_q.bptr[1:0]*8 +: 8];
    assign first    = st_q.ready && (st_q.bptr == '0);
    assign last     = st_q.ready && (st_q.bptr == BP_W'(BYTES - 1));
endmodule

// File: rtl/kh_rx_buf.sv
module kh_rx_buf #(
    parameter int WORDS = 9,
    parameter int BYTES = 36
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic [7:0]  in_byte,
    input  logic        rd_stb,
    input  logic        ovr_clr,
    output logic [31:0] rd_word,
    output logic        avail,
    output logic        ovr
);
    localparam int WP_W = $clog2(WORDS);
    localparam int BP_W = $clog2(BYTES);

    typedef struct packed {
        logic [WORDS-1:0][31:0] mem;
        logic [BP_W-1:0]        bcnt;
        logic [WP_W-1:0]        rptr;
        logic                   active;
        logic                   avail;
        logic                   ovr;
    } rx_state_t;

    rx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ovr_clr) st_d.ovr = 1'b0;
        if (in_valid) begin
            if (in_start) begin
                if (st_q.avail) begin
                    st_d.active = 1'b0;
                    st_d.ovr    = 1'b1;
                end else begin
                    st_d.mem[0][7:0] = in_byte;
                    st_d.bcnt        = BP_W'(1);
                    st_d.active      = 1'b1;
                end
            end else if (st_q.active) begin
                st_d.mem[st_q.bcnt[BP_W-1:2]][st_q.bcnt[1:0]*8 +: 8] = in_byte;
                if (st_q.bcnt == BP_W'(BYTES - 1)) begin
                    st_d.active = 1'b0;
                    st_d.avail  = 1'b1;
                    st_d.bcnt   = '0;
                    st_d.rptr   = '0;
                end else begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end
        end
        if (rd_stb && st_q.avail) begin
            if (st_q.rptr == WP_W'(WORDS - 1)) begin
                st_d.rptr  = '0;
                st_d.avail = 1'b0;
            end else begin
                st_d.rptr = st_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = st_q.avail ? st_q.mem[st_q.rptr] : 32'h0;
    assign avail   = st_q.avail;
    assign ovr     = st_q.ovr;
endmodule

// File: rtl/kh_pkt_buf.sv
module kh_pkt_buf #(
    parameter int ADDR_W    = 4,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    input  logic              tx_accept,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic              rx_start,
    input  logic [7:0]        rx_data
);
    import kh_pkg::*;

    localparam int PKT_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int PKT_WORDS = PKT_BYTES / WORD_BYTES;

    typedef struct packed {
        logic [31:0] rdata;
    } bus_state_t;

    bus_state_t bs_q, bs_d;

    logic        sel_tx, sel_rx, sel_st;
    logic        tx_ready;
    logic        rx_avail;
    logic        rx_ovr;
    logic [31:0] rx_word;
    logic [31:0] status_word;

    assign sel_tx = (bus_addr == ADDR_W'(ADDR_TX_KEY));
    assign sel_rx = (bus_addr == ADDR_W'(ADDR_RX_KEY));
    assign sel_st = (bus_addr == ADDR_W'(ADDR_STATUS));

    kh_tx_buf #(.WORDS(PKT_WORDS), .BYTES(PKT_BYTES)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (bus_wr && sel_tx),
        .wdata    (bus_wdata),
        .accept   (tx_accept),
        .ready    (tx_ready),
        .byte_out (tx_data),
        .first    (tx_first),
        .last     (tx_last)
    );

    kh_rx_buf #(.WORDS(PKT_WORDS), .BYTES(PKT_BYTES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_start (rx_start),
        .in_byte  (rx_data),
        .rd_stb   (bus_rd && sel_rx),
        .ovr_clr  (bus_rd && sel_st),
        .rd_word  (rx_word),
        .avail    (rx_avail),
        .ovr      (rx_ovr)
    );

    always_comb begin
        status_word              = '0;
        status_word[ST_TX_READY] = tx_ready;
        status_word[ST_RX_AVAIL] = rx_avail;
        status_word[ST_RX_OVR]   = rx_ovr;
    end

    always_comb begin
        bs_d = bs_q;
        if (bus_rd) begin
            if (sel_rx)      bs_d.rdata = rx_word;
            else if (sel_st) bs_d.rdata = status_word;
            else             bs_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;
    assign tx_valid  = tx_ready;
endmodule

// File: rtl/kh_pkt_buf_chk.sv
module kh_pkt_buf_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              tx_valid,
    input logic              tx_accept,
    input logic [7:0]        tx_data,
    input logic              tx_first,
    input logic              tx_last,
    input logic              rx_valid,
    input logic              rx_start,
    input logic              rx_avail,
    input logic              rx_ovr
);
    import kh_pkg::*;

    assert_tx_rise_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(bus_wr && bus_addr == ADDR_W'(ADDR_TX_KEY)));

    assert_marks_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_first, tx_last}) && ((tx_first || tx_last) -> tx_valid));

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_accept) |=> (tx_valid && $stable(tx_data)));

    assert_tx_fall_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> $past(tx_last && tx_accept));

    assert_avail_fall_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail) |-> $past(bus_rd && bus_addr == ADDR_W'(ADDR_RX_KEY)));

    assert_ovr_rise_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_valid && rx_start && rx_avail));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == ADDR_W'(ADDR_STATUS)) |-> (bus_rdata[31:3] == 29'h0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind kh_pkt_buf kh_pkt_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_accept (tx_accept),
    .tx_data   (tx_data),
    .tx_first  (tx_first),
    .tx_last   (tx_last),
    .rx_valid  (rx_valid),
    .rx_start  (rx_start),
    .rx_avail  (rx_avail),
    .rx_ovr    (rx_ovr)
);

// File: tb/kh_pkt_buf_test.sv
`timescale 1ns/1ps
module kh_pkt_buf_test;
    localparam int ADDR_W = 4;
    localparam int NB     = 36;
    localparam int NW     = 9;
    localparam int NSEED  = 4;
    localparam int SEEDS [NSEED] = '{17, 90, 203, 5};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              tx_valid;
    logic              tx_accept = 1'b0;
    logic [7:0]        tx_data;
    logic              tx_first, tx_last;
    logic              rx_valid = 1'b0;
    logic              rx_start = 1'b0;
    logic [7:0]        rx_data = '0;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    kh_pkt_buf #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_accept(tx_accept), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_start(rx_start), .rx_data(rx_data)
    );

    function automatic logic [7:0] pb(int seed, int i);
        return 8'((seed * 7 + i * 13 + (i >> 2)) ^ (seed >> 3));
    endfunction

    function automatic logic [31:0] pw(int seed, int w);
        return {pb(seed, 4*w+3), pb(seed, 4*w+2), pb(seed, 4*w+1), pb(seed, 4*w)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(int addr, logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr); bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    task automatic rx_send(int seed, int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_start = (i == 0); rx_data = pb(seed, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_start = 1'b0;
    endtask

    task automatic tx_fill(int seed);
        for (int w = 0; w < NW; w++) bus_write(0, pw(seed, w));
    endtask

    task automatic tx_drain_check(int seed, string req);
        int bad = 0;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            if (tx_valid !== 1'b1 || tx_data !== pb(seed, i) ||
                tx_first !== (i == 0) || tx_last !== (i == NB - 1)) begin
                bad++;
                if (bad == 1) $display("FAIL %s: byte %0d actual %h/%b expected %h/%b",
                                       req, i, tx_data, tx_valid, pb(seed, i), 1'b1);
            end
            tx_accept = 1'b1;
        end
        @(negedge clk);
        tx_accept = 1'b0;
        n_run++;
        if (bad != 0) n_fail++;
        check("R4 tx_valid low after last", 32'(tx_valid), 32'h0);
    endtask

    task automatic rx_read_check(int seed, string req);
        logic [31:0] d;
        for (int w = 0; w < NW; w++) begin
            bus_read(1, d);
            check(req, d, pw(seed, w));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
        bus_read(2, d);  check("R1 status", d, 32'h0);
        bus_read(1, d);  check("R1 rx keyhole empty", d, 32'h0);

        // vector table: one packet per seed through both slots (R3 R6 R7)
        for (int s = 0; s < NSEED; s++) begin
            rx_send(SEEDS[s], NB);
            bus_read(2, d);  check("R6 avail set", d, 32'h2);
            rx_read_check(SEEDS[s], "R7 rx word");
            bus_read(2, d);  check("R7 avail clear", d, 32'h0);
            tx_fill(SEEDS[s]);
            check("R2 tx_valid after ninth", 32'(tx_valid), 32'h1);
            tx_drain_check(SEEDS[s], "R3 tx byte order");
        end

        // R2: eight writes not enough
        for (int w = 0; w < 8; w++) bus_write(0, pw(44, w));
        check("R2 no ready after eight", 32'(tx_valid), 32'h0);
        bus_read(2, d);  check("R2 status bit0 low", d, 32'h0);
        bus_write(0, pw(44, 8));
        bus_read(2, d);  check("R2 status bit0 high", d, 32'h1);

        // R5: writes while ready ignored
        tx_fill(77);
        check("R5 still ready", 32'(tx_valid), 32'h1);

        // R4: stall holds byte
        d = 32'(tx_data);
        repeat (4) @(negedge clk);
        check("R4 stall holds data", 32'(tx_data), d);
        check("R4 stall holds valid", 32'(tx_valid), 32'h1);
        tx_drain_check(44, "R5 packet unchanged");

        // R10: restart mid-packet
        rx_send(61, 10);
        bus_read(2, d);  check("R10 partial not avail", d, 32'h0);
        rx_send(62, NB);
        rx_read_check(62, "R10 restarted packet");

        // R8: overrun
        rx_send(120, NB);
        rx_send(121, NB);
        bus_read(2, d);  check("R8 overrun and avail", d, 32'h6);
        bus_read(2, d);  check("R9 overrun cleared", d, 32'h2);
        rx_read_check(120, "R8 stored packet kept");

        // R9: other addresses read zero
        bus_read(3, d);  check("R9 unused addr", d, 32'h0);
        bus_read(15, d); check("R9 top addr", d, 32'h0);
        bus_read(1, d);  check("R9 rx keyhole empty", d, 32'h0);

        // R11: rdata holds without read
        rx_send(9, NB);
        bus_read(1, d);
        repeat (3) @(negedge clk);
        check("R11 rdata hold", bus_rdata, pw(9, 0));
        for (int w = 1; w < NW; w++) begin
            bus_read(1, d);
            check("R7 pointer wrap", d, pw(9, w));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule